// File: doc/BRIEF.md
# DMA Channel Arbiter with Fixed and Rotating Priority Classes

This block decides which of several DMA channels owns a single shared transfer engine. Every channel keeps a request-status flag that is raised by a one-cycle software request pulse or by a level request from its peripheral. The flag is honoured only while the channel is enabled. Each channel sits in one of two priority classes. Fixed-priority channels always win over the rotating pool. Inside the rotating pool, channels take turns starting after the last rotating winner.

When a channel wins, the block raises its one-hot grant and loads a transfer budget. A burst-type channel gets 128 transfers for burst code 0, and each higher code halves that down to 1 for code 7. A single-type channel gets a budget of 1. The engine reports every completed transfer, and marks the final transfer of a channel's task. The grant is held unchanged until the budget runs out, the task ends, or a disabled channel finishes its current transfer. After release, the block re-arbitrates in the following cycle.

Software moves channels between the two classes through separate set and clear write ports, and reads the class back. Software also controls the enable bits, and can pause or abort a channel. Either action drops the channel's enable bit.

Top module: `dmaChanArbiter`

## Requirements
- R1: Out of reset, grant, grantLen, reqStatus, chanEn and priState are all zero, and nothing is granted until a request arrives.
- R2: A priority-set write makes every channel whose data bit is 1 fixed-priority and leaves the others unchanged. priState reads the class of each channel, where 1 means fixed.
- R3: A priority-clear write returns every channel whose data bit is 1 to the rotating pool and leaves the others unchanged. If a set and a clear hit the same channel in one cycle, the set wins.
- R4: When any requesting fixed-priority channel exists, the lowest-indexed fixed-priority channel wins over every rotating channel.
- R5: Among rotating channels, the winner is the first requester found after the previous rotating winner, in increasing index order with wrap-around. After reset, the search starts at channel 0.
- R6: A burst-type channel (singleXfer bit 0) with 3-bit code c in burstCode[3i+2:3i] receives grantLen = 128 >> c. So code 0 gives 128, code 3 gives 16, code 5 gives 4 and code 7 gives 1.
- R7: A single-type channel (singleXfer bit 1) receives grantLen 1 whatever its burst code, and loses the grant after each transfer.
- R8: A software request pulse, or a peripheral request, is ignored for a channel whose chanEn bit is 0. A disabled channel is never newly granted.
- R9: reqStatus[i] rises the clock edge after an accepted request. It falls on the edge at which a transfer flagged with xferLast completes while channel i is granted.
- R10: A grant is raised two edges after the request pulse is applied, and stays unchanged while xferStep is low. It drops on the edge of the xferStep that uses up the budget or carries xferLast. If requests are still pending, a new grant appears on the next edge.
- R11: A pause or abort bit clears the channel's enable bit on the next edge. A write to the enable register in the same cycle loses to it. An idle channel's reqStatus then clears one edge later. A granted channel keeps its grant and flag until its next xferStep, at which point both clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enWe | input | 1 | Write strobe for the enable register |
| enData | input | NUM_CH | New enable bits |
| pauseReq | input | NUM_CH | Per-channel pause pulse |
| abortReq | input | NUM_CH | Per-channel abort pulse |
| priSetWe | input | 1 | Write strobe for the priority-set port |
| priSetData | input | NUM_CH | Channels to make fixed-priority |
| priClrWe | input | 1 | Write strobe for the priority-clear port |
| priClrData | input | NUM_CH | Channels to return to the rotating pool |
| swReq | input | NUM_CH | Software request pulses |
| periphReq | input | NUM_CH | Peripheral request levels |
| singleXfer | input | NUM_CH | Transfer type per channel, where 1 means single |
| burstCode | input | NUM_CH*BURST_W | Burst code per channel |
| xferStep | input | 1 | Engine finished one transfer for the granted channel |
| xferLast | input | 1 | That transfer was the last of the channel's task |
| chanEn | output | NUM_CH | Enable register |
| priState | output | NUM_CH | Priority class per channel |
| reqStatus | output | NUM_CH | Request-status flags |
| grant | output | NUM_CH | One-hot grant |
| grantLen | output | CNT_W | Transfer budget of the current grant |

## Verification
The arbitration order is tested with three request patterns. Simultaneous requests from two fixed channels and one rotating channel show whether class beats index, and whether the lowest fixed index wins. A set of rotating-only requests placed after a known last winner shows whether the search resumes after that winner rather than restarting at channel 0. Repeated requests from a single channel whose budget is shorter than its task show whether a budget boundary differs from task completion: the flag must stay high and the grant must come back. Pause and abort are applied to one granted channel and one waiting channel in the same cycle, which separates the immediate flag clear from the deferred one.

// File: rtl/arbPkg.sv
package arbPkg;

  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_BUSY = 1'b1
  } arbState_t;

  // strobes from control to datapath, at most one high per cycle
  typedef struct packed {
    logic grantLoad;
    logic countDec;
    logic grantRelease;
  } arbStrobe_t;

endpackage

// File: rtl/arbPicker.sv
module arbPicker #(
  parameter int NUM_CH = 5,
  parameter int IDX_W  = 3
) (
  input  logic [NUM_CH-1:0] eligible,
  input  logic [NUM_CH-1:0] fixedMask,
  input  logic [IDX_W-1:0]  rrLast,
  output logic [NUM_CH-1:0] winnerOh,
  output logic [IDX_W-1:0]  winnerIdx,
  output logic              winnerFixed,
  output logic              anyEligible
);

  logic [NUM_CH-1:0] fixedReq;
  logic [NUM_CH-1:0] rrReq;
  logic              found;

  assign fixedReq    = eligible & fixedMask;
  assign rrReq       = eligible & ~fixedMask;
  assign anyEligible = |eligible;

  always_comb begin
    found       = 1'b0;
    winnerIdx   = '0;
    winnerFixed = 1'b0;
    // fixed class: lowest index first
    for (int i = 0; i < NUM_CH; i++) begin
      if (!found && fixedReq[i]) begin
        found       = 1'b1;
        winnerIdx   = IDX_W'(i);
        winnerFixed = 1'b1;
      end
    end
    // rotating class: search begins just after the last rotating winner
    for (int k = 1; k <= NUM_CH; k++) begin
      int cand;
      cand = int'(rrLast) + k;
      if (cand >= NUM_CH) cand = cand - NUM_CH;
      if (!found && rrReq[cand[IDX_W-1:0]]) begin
        found     = 1'b1;
        winnerIdx = cand[IDX_W-1:0];
      end
    end
    winnerOh = found ? (NUM_CH'(1) << winnerIdx) : '0;
  end

endmodule

// File: rtl/arbDatapath.sv
module arbDatapath
  import arbPkg::*;
#(
  parameter int NUM_CH  = 5,
  parameter int BURST_W = 3,
  parameter int IDX_W   = 3,
  parameter int CNT_W   = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      enWe,
  input  logic [NUM_CH-1:0]         enData,
  input  logic [NUM_CH-1:0]         pauseReq,
  input  logic [NUM_CH-1:0]         abortReq,
  input  logic                      priSetWe,
  input  logic [NUM_CH-1:0]         priSetData,
  input  logic                      priClrWe,
  input  logic [NUM_CH-1:0]         priClrData,
  input  logic [NUM_CH-1:0]         swReq,
  input  logic [NUM_CH-1:0]         periphReq,
  input  logic [NUM_CH-1:0]         singleXfer,
  input  logic [NUM_CH*BURST_W-1:0] burstCode,
  input  logic                      xferStep,
  input  logic                      xferLast,
  input  arbStrobe_t                strobe,
  output logic [NUM_CH-1:0]         chanEn,
  output logic [NUM_CH-1:0]         priFixed,
  output logic [NUM_CH-1:0]         reqStatus,
  output logic [NUM_CH-1:0]         grantQ,
  output logic [CNT_W-1:0]          grantLen,
  output logic                      anyEligible,
  output logic                      budgetOne,
  output logic                      grantedDisabled
);

  logic [NUM_CH-1:0]  eligible;
  logic [NUM_CH-1:0]  winnerOh;
  logic [IDX_W-1:0]   winnerIdx;
  logic               winnerFixed;
  logic [IDX_W-1:0]   rrLast;
  logic [CNT_W-1:0]   budget;
  logic [CNT_W-1:0]   winLen;
  logic [BURST_W-1:0] codeArr [NUM_CH];
  logic [BURST_W-1:0] winCode;
  logic [NUM_CH-1:0]  killMask;
  logic [NUM_CH-1:0]  reqSet;
  logic [NUM_CH-1:0]  reqClr;
  logic [NUM_CH-1:0]  priNext;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : gUnpack
      assign codeArr[g] = burstCode[g*BURST_W +: BURST_W];
    end
  endgenerate

  assign eligible = reqStatus & chanEn;

  arbPicker #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) uPicker (
    .eligible    (eligible),
    .fixedMask   (priFixed),
    .rrLast      (rrLast),
    .winnerOh    (winnerOh),
    .winnerIdx   (winnerIdx),
    .winnerFixed (winnerFixed),
    .anyEligible (anyEligible)
  );

  // budget = max >> code; (2^W-1)-code equals the bitwise inverse of code
  assign winCode = codeArr[winnerIdx];
  assign winLen  = singleXfer[winnerIdx] ? CNT_W'(1)
                                         : (CNT_W'(1) << (~winCode));

  assign killMask        = pauseReq | abortReq;
  assign budgetOne       = (budget == CNT_W'(1));
  assign grantedDisabled = |(grantQ & ~chanEn);

  // enable register: pause/abort beat a same-cycle write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chanEn <= '0;
    else if (enWe) chanEn <= enData & ~killMask;
    else chanEn <= chanEn & ~killMask;
  end

  // priority class: set wins over clear
  always_comb begin
    priNext = priFixed;
    if (priClrWe) priNext = priNext & ~priClrData;
    if (priSetWe) priNext = priNext | priSetData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) priFixed <= '0;
    else priFixed <= priNext;
  end

  // request-status flags
  assign reqSet = chanEn & (swReq | periphReq);
  assign reqClr = (~chanEn & ~grantQ)
                | (grantQ & {NUM_CH{xferStep}} & ({NUM_CH{xferLast}} | ~chanEn));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqStatus <= '0;
    else reqStatus <= (reqStatus | reqSet) & ~reqClr;
  end

  // grant, budget and rotation pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantQ   <= '0;
      budget   <= '0;
      grantLen <= '0;
      rrLast   <= IDX_W'(NUM_CH - 1);
    end else if (strobe.grantRelease) begin
      grantQ   <= '0;
      budget   <= '0;
      grantLen <= '0;
    end else if (strobe.grantLoad) begin
      grantQ   <= winnerOh;
      budget   <= winLen;
      grantLen <= winLen;
      if (!winnerFixed) rrLast <= winnerIdx;
    end else if (strobe.countDec) begin
      budget <= budget - CNT_W'(1);
    end
  end

  // ---------------- assertions ----------------
  assert_grant_onehot_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantQ));

  assert_grant_steady_R10: assert property (@(posedge clk) disable iff (!rstN)
    (grantQ != '0 && !xferStep) |=> $stable(grantQ));

  assert_budget_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    (grantQ != '0) |-> (budget != '0 && budget <= grantLen));

  assert_single_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    (grantQ != '0 && grantLen == CNT_W'(1) && xferStep) |=> (grantQ == '0));

  assert_fixed_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.grantLoad && (eligible & priFixed) != '0)
      |=> ((grantQ & $past(priFixed)) != '0));

  assert_killed_flag_R11: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((reqStatus & ~$past(chanEn) & ~$past(grantQ)) == '0));

endmodule

// File: rtl/arbControl.sv
module arbControl
  import arbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyEligible,
  input  logic       xferStep,
  input  logic       xferLast,
  input  logic       budgetOne,
  input  logic       grantedDisabled,
  output arbStrobe_t strobe
);

  arbState_t state;
  arbState_t stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ARB_IDLE: begin
        if (anyEligible) begin
          strobe.grantLoad = 1'b1;
          stateNext        = ARB_BUSY;
        end
      end
      ARB_BUSY: begin
        if (xferStep) begin
          if (xferLast || budgetOne || grantedDisabled) begin
            strobe.grantRelease = 1'b1;
            stateNext           = ARB_IDLE;
          end else begin
            strobe.countDec = 1'b1;
          end
        end
      end
      default: stateNext = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ARB_IDLE;
    else state <= stateNext;
  end

  assert_budget_boundary_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ARB_BUSY && xferStep && budgetOne) |=> (state == ARB_IDLE));

  assert_task_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ARB_BUSY && xferStep && xferLast) |=> (state == ARB_IDLE));

endmodule

// File: rtl/dmaChanArbiter.sv
module dmaChanArbiter
  import arbPkg::*;
#(
  parameter int NUM_CH  = 5,
  parameter int BURST_W = 3,
  localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CNT_W  = (1 << BURST_W)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      enWe,
  input  logic [NUM_CH-1:0]         enData,
  input  logic [NUM_CH-1:0]         pauseReq,
  input  logic [NUM_CH-1:0]         abortReq,
  input  logic                      priSetWe,
  input  logic [NUM_CH-1:0]         priSetData,
  input  logic                      priClrWe,
  input  logic [NUM_CH-1:0]         priClrData,
  input  logic [NUM_CH-1:0]         swReq,
  input  logic [NUM_CH-1:0]         periphReq,
  input  logic [NUM_CH-1:0]         singleXfer,
  input  logic [NUM_CH*BURST_W-1:0] burstCode,
  input  logic                      xferStep,
  input  logic                      xferLast,
  output logic [NUM_CH-1:0]         chanEn,
  output logic [NUM_CH-1:0]         priState,
  output logic [NUM_CH-1:0]         reqStatus,
  output logic [NUM_CH-1:0]         grant,
  output logic [CNT_W-1:0]          grantLen
);

  arbStrobe_t strobe;
  logic       anyEligible;
  logic       budgetOne;
  logic       grantedDisabled;

  arbDatapath #(
    .NUM_CH(NUM_CH), .BURST_W(BURST_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) uDatapath (
    .clk             (clk),
    .rstN            (rstN),
    .enWe            (enWe),
    .enData          (enData),
    .pauseReq        (pauseReq),
    .abortReq        (abortReq),
    .priSetWe        (priSetWe),
    .priSetData      (priSetData),
    .priClrWe        (priClrWe),
    .priClrData      (priClrData),
    .swReq           (swReq),
    .periphReq       (periphReq),
    .singleXfer      (singleXfer),
    .burstCode       (burstCode),
    .xferStep        (xferStep),
    .xferLast        (xferLast),
    .strobe          (strobe),
    .chanEn          (chanEn),
    .priFixed        (priState),
    .reqStatus       (reqStatus),
    .grantQ          (grant),
    .grantLen        (grantLen),
    .anyEligible     (anyEligible),
    .budgetOne       (budgetOne),
    .grantedDisabled (grantedDisabled)
  );

  arbControl uControl (
    .clk             (clk),
    .rstN            (rstN),
    .anyEligible     (anyEligible),
    .xferStep        (xferStep),
    .xferLast        (xferLast),
    .budgetOne       (budgetOne),
    .grantedDisabled (grantedDisabled),
    .strobe          (strobe)
  );

endmodule

// File: tb/tb_dmaChanArbiter.sv
`timescale 1ns/1ps
module tb_dmaChanArbiter;

  localparam int N  = 5;
  localparam int BW = 3;

  logic          clk = 1'b0;
  logic          rstN;
  logic          enWe;
  logic [N-1:0]  enData, pauseReq, abortReq;
  logic          priSetWe, priClrWe;
  logic [N-1:0]  priSetData, priClrData;
  logic [N-1:0]  swReq, periphReq, singleXfer;
  logic [N*BW-1:0] burstCode;
  logic          xferStep, xferLast;
  logic [N-1:0]  chanEn, priState, reqStatus, grant;
  logic [7:0]    grantLen;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dmaChanArbiter #(.NUM_CH(N), .BURST_W(BW)) dut (
    .clk(clk), .rstN(rstN), .enWe(enWe), .enData(enData),
    .pauseReq(pauseReq), .abortReq(abortReq),
    .priSetWe(priSetWe), .priSetData(priSetData),
    .priClrWe(priClrWe), .priClrData(priClrData),
    .swReq(swReq), .periphReq(periphReq), .singleXfer(singleXfer),
    .burstCode(burstCode), .xferStep(xferStep), .xferLast(xferLast),
    .chanEn(chanEn), .priState(priState), .reqStatus(reqStatus),
    .grant(grant), .grantLen(grantLen)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulseSw(input logic [N-1:0] m);
    swReq = m; tick(); swReq = '0;
  endtask

  task automatic stepOnce(input logic last);
    xferStep = 1'b1; xferLast = last; tick(); xferStep = 1'b0; xferLast = 1'b0;
  endtask

  task automatic setCode(input int ch, input logic [BW-1:0] c);
    burstCode[ch*BW +: BW] = c;
  endtask

  task automatic writeEn(input logic [N-1:0] m);
    enWe = 1'b1; enData = m; tick(); enWe = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 grant", grant, 0);
    chk("R1 grantLen", grantLen, 0);
    chk("R1 reqStatus", reqStatus, 0);
    chk("R1 chanEn", chanEn, 0);
    chk("R1 priState", priState, 0);
  endtask

  task automatic testPriorityPorts();
    priSetWe = 1; priSetData = 5'b00101; tick(); priSetWe = 0;
    chk("R2 set", priState, 5'b00101);
    priSetWe = 1; priSetData = 5'b00010; tick(); priSetWe = 0;
    chk("R2 zero bits keep", priState, 5'b00111);
    priClrWe = 1; priClrData = 5'b00001; tick(); priClrWe = 0;
    chk("R3 clear", priState, 5'b00110);
    priSetWe = 1; priSetData = 5'b01000; priClrWe = 1; priClrData = 5'b01010; tick();
    priSetWe = 0; priClrWe = 0;
    chk("R3 set beats clear", priState, 5'b01100);
    priClrWe = 1; priClrData = 5'h1F; tick(); priClrWe = 0;
    chk("R3 clear all", priState, 0);
  endtask

  task automatic testDisabledIgnored();
    pulseSw(5'b00100);
    chk("R8 sw ignored flag", reqStatus, 0);
    tick();
    chk("R8 sw ignored grant", grant, 0);
  endtask

  task automatic testBurstGrant();
    writeEn(5'h1F);
    setCode(1, 3'd5);
    pulseSw(5'b00010);
    chk("R9 flag rises", reqStatus, 5'b00010);
    chk("R10 no grant yet", grant, 0);
    tick();
    chk("R10 grant ch1", grant, 5'b00010);
    chk("R6 code5 len4", grantLen, 4);
    for (int i = 0; i < 3; i++) stepOnce(1'b0);
    chk("R10 grant held in budget", grant, 5'b00010);
    stepOnce(1'b0);
    chk("R10 budget release", grant, 0);
    chk("R9 flag kept at budget end", reqStatus, 5'b00010);
    tick();
    chk("R10 regrant", grant, 5'b00010);
    stepOnce(1'b1);
    chk("R9 flag clears on last", reqStatus, 0);
    chk("R10 release on last", grant, 0);
    tick();
    chk("R10 stays idle", grant, 0);
  endtask

  task automatic testBurstCodes();
    setCode(2, 3'd0); pulseSw(5'b00100); tick();
    chk("R6 code0 len128", grantLen, 128);
    stepOnce(1'b1);
    setCode(2, 3'd7); pulseSw(5'b00100); tick();
    chk("R6 code7 len1", grantLen, 1);
    stepOnce(1'b1);
    setCode(2, 3'd3); pulseSw(5'b00100); tick();
    chk("R6 code3 len16", grantLen, 16);
    stepOnce(1'b1);
  endtask

  task automatic testSingle();
    singleXfer = 5'b01000; setCode(3, 3'd0);
    pulseSw(5'b01000); tick();
    chk("R7 single grant", grant, 5'b01000);
    chk("R7 single len", grantLen, 1);
    stepOnce(1'b0);
    chk("R7 released after one", grant, 0);
    chk("R7 flag kept", reqStatus, 5'b01000);
    tick();
    chk("R7 regranted", grant, 5'b01000);
    stepOnce(1'b1);
    singleXfer = '0;
  endtask

  task automatic testFixedClass();
    priSetWe = 1; priSetData = 5'b10100; tick(); priSetWe = 0;
    pulseSw(5'b10101); tick();
    chk("R4 lowest fixed wins", grant, 5'b00100);
    stepOnce(1'b1); tick();
    chk("R4 next fixed", grant, 5'b10000);
    stepOnce(1'b1); tick();
    chk("R4 rotating last", grant, 5'b00001);
    stepOnce(1'b1);
  endtask

  task automatic testRotation();
    priClrWe = 1; priClrData = 5'h1F; tick(); priClrWe = 0;
    pulseSw(5'b01011); tick();
    chk("R5 after ch0 comes ch1", grant, 5'b00010);
    stepOnce(1'b1); tick();
    chk("R5 then ch3", grant, 5'b01000);
    stepOnce(1'b1); tick();
    chk("R5 wrap to ch0", grant, 5'b00001);
    stepOnce(1'b1);
  endtask

  task automatic testPauseAbort();
    pulseSw(5'b00110); tick();
    chk("R5 ch1 wins", grant, 5'b00010);
    pauseReq = 5'b00010; abortReq = 5'b00100; enWe = 1; enData = 5'h1F; tick();
    pauseReq = '0; abortReq = '0; enWe = 0;
    chk("R11 enables cleared", chanEn, 5'b11001);
    chk("R11 grant held", grant, 5'b00010);
    tick();
    chk("R11 idle flag cleared", reqStatus, 5'b00010);
    chk("R11 grant still held", grant, 5'b00010);
    stepOnce(1'b0);
    chk("R11 grant dropped after transfer", grant, 0);
    chk("R11 flag dropped after transfer", reqStatus, 0);
    tick();
    chk("R8 disabled not granted", grant, 0);
    pulseSw(5'b00010);
    chk("R8 sw to paused ignored", reqStatus, 0);
    writeEn(5'h1F);
  endtask

  task automatic testPeriph();
    periphReq = 5'b10000; tick();
    chk("R9 periph flag", reqStatus, 5'b10000);
    tick();
    chk("R9 periph grant", grant, 5'b10000);
    periphReq = '0;
    stepOnce(1'b1);
    chk("R9 periph flag clears", reqStatus, 0);
    chk("R10 periph release", grant, 0);
  endtask

  initial begin
    rstN = 0; enWe = 0; enData = '0; pauseReq = '0; abortReq = '0;
    priSetWe = 0; priSetData = '0; priClrWe = 0; priClrData = '0;
    swReq = '0; periphReq = '0; singleXfer = '0; burstCode = '0;
    xferStep = 0; xferLast = 0;
    repeat (3) tick();
    rstN = 1;
    tick();
    testReset();
    testPriorityPorts();
    testDisabledIgnored();
    testBurstGrant();
    testBurstCodes();
    testSingle();
    testFixedClass();
    testRotation();
    testPauseAbort();
    testPeriph();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule